// File: doc/BRIEF.md
# Tiled Framebuffer Address Generator

This block turns a pixel coordinate into the byte address of that pixel inside a render surface. A surface can be stored in one of four layouts: plain row-major, a grid of 32-byte micro tiles, a grid of 2 KB macro tiles, or 2 KB macro tiles that are themselves built from 32-byte micro tiles. In the last layout each micro tile spans two pixel rows. A request carries the coordinate, the layout code, the pixel size in bytes, the surface pitch, the surface base address and an optional drawable origin. The origin is added to the coordinate before translation, which is how depth and stencil surfaces are addressed.

Requests enter on a valid/ready handshake. Each accepted request produces exactly one result, in order, on a registered output with its own valid/ready handshake. A stalled output holds its value and back-pressures the input. A pixel size other than 1, 2 or 4 bytes produces no address. The result is flagged as an error instead.

Top module: `tile_addr_gen`

## Requirements
- R1: With `in_linear` high, or with `in_layout` = 2'b00, offset = x*bpp + y*pitch.
- R2: With `in_layout` = 2'b01 (micro tiles only), micro width mw = 32/bpp pixels and tiles per row t = ceil(pitch/32). offset = y*t*32 + (x/mw)*32 + (x mod mw)*bpp.
- R3: With `in_layout` = 2'b10 (macro tiles only), mw = 32/bpp, macro width MW = 256/bpp and t = floor(pitch/MW). offset = (y/8)*t*2048 + (y mod 8)*256 + (x/MW)*2048 + ((x mod MW)/mw)*32 + (x mod mw)*bpp.
- R4: With `in_layout` = 2'b11 (macro built from micro tiles), mw = 16/bpp, MW = 128/bpp and t = floor(pitch/MW). offset = (y/16)*t*2048 + ((y mod 16)/2)*256 + (y mod 2)*16 + (x/MW)*2048 + ((x mod MW)/mw)*32 + (x mod mw)*bpp.
- R5: With `in_org_en` high, x+`in_org_x` and y+`in_org_y` (each modulo 2^16) replace x and y before translation. With `in_org_en` low the origin inputs have no effect.
- R6: A bpp value other than 1, 2 or 4 yields a result with `out_err` = 1 and `out_addr` = 0. Valid values yield `out_err` = 0.
- R7: `out_addr` = (`in_base` + offset) modulo 2^32.
- R8: A request accepted at a rising edge appears on `out_valid` after the following rising edge. Results leave in acceptance order, one per request.
- R9: While `out_valid` is high and `out_ready` is low, `out_addr` and `out_err` stay unchanged and `in_ready` is low.
- R10: A synchronous reset (`rst` high at a rising edge) clears every pipeline valid bit. `out_valid` is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous reset, active high |
| in_valid | input | 1 | request valid |
| in_ready | output | 1 | request accepted when high with in_valid |
| in_x | input | 16 | pixel column |
| in_y | input | 16 | pixel row |
| in_layout | input | 2 | bit0 micro tiling, bit1 macro tiling |
| in_linear | input | 1 | force row-major addressing |
| in_bpp | input | 3 | bytes per pixel (1, 2, 4 legal) |
| in_pitch | input | 16 | surface pitch |
| in_base | input | 32 | surface base byte address |
| in_org_en | input | 1 | add drawable origin to coordinate |
| in_org_x | input | 16 | origin column |
| in_org_y | input | 16 | origin row |
| out_valid | output | 1 | result valid |
| out_ready | input | 1 | result consumed when high with out_valid |
| out_addr | output | 32 | byte address |
| out_err | output | 1 | illegal pixel size, address withheld |

## Verification
The bench targets the points where the tile geometry changes with pixel size: x just below and just past a micro-tile and a macro-tile edge, odd and even rows in the paired-row layout, and pitches that are not multiples of 32. A shift amount off by one would move whole tiles to the wrong place, and a missing round-up in the micro-only mode would make rows overlap. It also wraps the coordinate through the origin add and the address through the base add, feeds illegal pixel sizes, and holds the output under back-pressure and through a mid-flight reset. A design that dropped or duplicated a stalled result would upset the in-order scoreboard.

// File: rtl/tile_addr_pkg.sv
package tile_addr_pkg;

  localparam int unsigned OFF_W = 32;

  typedef enum logic [1:0] {
    LAY_LINEAR = 2'b00,
    LAY_MICRO  = 2'b01,
    LAY_MACRO  = 2'b10,
    LAY_BOTH   = 2'b11
  } layout_e;

  typedef struct packed {
    logic             err;
    logic [OFF_W-1:0] row;   // row-of-tiles product, already shifted
    logic [OFF_W-1:0] rest;  // all remaining offset terms
  } terms_t;

  function automatic logic bpp_bad(input logic [2:0] bpp);
    return !(bpp == 3'd1 || bpp == 3'd2 || bpp == 3'd4);
  endfunction

  function automatic logic [4:0] bpp_shift(input logic [2:0] bpp);
    case (bpp)
      3'd2:    return 5'd1;
      3'd4:    return 5'd2;
      default: return 5'd0;
    endcase
  endfunction

  function automatic logic [OFF_W-1:0] lo_mask(input logic [4:0] n);
    return (OFF_W'(1) << n) - OFF_W'(1);
  endfunction

  // Offset split into two addends; the caller sums them.
  function automatic terms_t tile_terms(input logic [OFF_W-1:0] xw,
                                        input logic [OFF_W-1:0] yw,
                                        input logic [OFF_W-1:0] pw,
                                        input logic [1:0]       lay,
                                        input logic             lin,
                                        input logic [2:0]       bpp);
    terms_t           t;
    logic [4:0]       s;
    logic [4:0]       mic_lg;
    logic [4:0]       mac_lg;
    logic [OFF_W-1:0] ridx;
    logic [OFF_W-1:0] tpr;
    logic [4:0]       rsh;
    s      = bpp_shift(bpp);
    t.err  = bpp_bad(bpp);
    t.rest = '0;
    mic_lg = 5'd5 - s;
    mac_lg = 5'd8 - s;
    ridx   = yw;
    tpr    = pw;
    rsh    = 5'd0;
    if (lin || layout_e'(lay) == LAY_LINEAR) begin
      t.rest = xw << s;
    end else begin
      case (layout_e'(lay))
        LAY_MICRO: begin
          tpr    = (pw + OFF_W'(31)) >> 5;
          rsh    = 5'd5;
          t.rest = ((xw >> mic_lg) << 5) + ((xw & lo_mask(mic_lg)) << s);
        end
        LAY_MACRO: begin
          ridx   = yw >> 3;
          tpr    = pw >> mac_lg;
          rsh    = 5'd11;
          t.rest = ((yw & OFF_W'(7)) << 8) + ((xw >> mac_lg) << 11)
                 + (((xw & lo_mask(mac_lg)) >> mic_lg) << 5)
                 + ((xw & lo_mask(mic_lg)) << s);
        end
        default: begin // both levels: rows paired inside each micro tile
          mic_lg = 5'd4 - s;
          mac_lg = 5'd7 - s;
          ridx   = yw >> 4;
          tpr    = pw >> mac_lg;
          rsh    = 5'd11;
          t.rest = (((yw & OFF_W'(15)) >> 1) << 8) + ((yw & OFF_W'(1)) << 4)
                 + ((xw >> mac_lg) << 11)
                 + (((xw & lo_mask(mac_lg)) >> mic_lg) << 5)
                 + ((xw & lo_mask(mic_lg)) << s);
        end
      endcase
    end
    t.row = (ridx * tpr) << rsh;
    return t;
  endfunction

endpackage

// File: rtl/tile_addr_terms.sv
module tile_addr_terms
  import tile_addr_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned PW = 16
) (
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] y,
  input  logic [1:0]    layout,
  input  logic          linear,
  input  logic [2:0]    bpp,
  input  logic [PW-1:0] pitch,
  input  logic          org_en,
  input  logic [CW-1:0] org_x,
  input  logic [CW-1:0] org_y,
  output terms_t        terms
);
  logic [CW-1:0] cx;
  logic [CW-1:0] cy;

  assign cx = org_en ? x + org_x : x;
  assign cy = org_en ? y + org_y : y;

  assign terms = tile_terms(OFF_W'(cx), OFF_W'(cy), OFF_W'(pitch),
                            layout, linear, bpp);
endmodule

// File: rtl/tile_addr_sum.sv
module tile_addr_sum
  import tile_addr_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  terms_t        terms,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] addr,
  output logic          err
);
  assign err  = terms.err;
  assign addr = terms.err ? '0 : base + AW'(terms.row) + AW'(terms.rest);
endmodule

// File: rtl/tile_addr_gen.sv
module tile_addr_gen
  import tile_addr_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter int unsigned PW = 16,
  parameter int unsigned AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [CW-1:0] in_x,
  input  logic [CW-1:0] in_y,
  input  logic [1:0]    in_layout,
  input  logic          in_linear,
  input  logic [2:0]    in_bpp,
  input  logic [PW-1:0] in_pitch,
  input  logic [AW-1:0] in_base,
  input  logic          in_org_en,
  input  logic [CW-1:0] in_org_x,
  input  logic [CW-1:0] in_org_y,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic          out_err
);
  // named pipeline events
  logic          advance;
  logic          accept;
  logic          s1_vld;
  terms_t        s1_terms;
  logic [AW-1:0] s1_base;
  terms_t        t_next;
  logic [AW-1:0] sum_addr;
  logic          sum_err;

  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;
  assign accept   = in_valid && advance;

  tile_addr_terms #(.CW(CW), .PW(PW)) terms_i (
    .x(in_x), .y(in_y), .layout(in_layout), .linear(in_linear),
    .bpp(in_bpp), .pitch(in_pitch), .org_en(in_org_en),
    .org_x(in_org_x), .org_y(in_org_y), .terms(t_next)
  );

  // stage 1: terms
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld <= 1'b0;
    end else if (advance) begin
      s1_vld <= in_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_terms <= t_next;
      s1_base  <= in_base;
    end
  end

  tile_addr_sum #(.AW(AW)) sum_i (
    .terms(s1_terms), .base(s1_base), .addr(sum_addr), .err(sum_err)
  );

  // stage 2: sum plus base
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (advance) begin
      out_valid <= s1_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (advance && s1_vld) begin
      out_addr <= sum_addr;
      out_err  <= sum_err;
    end
  end
endmodule

// File: rtl/tile_addr_gen_chk.sv
module tile_addr_gen_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          s1_vld,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] out_addr,
  input logic          out_err
);
  p_hold_out_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_err)));

  p_ready_low_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  p_err_addr_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_err) |-> (out_addr == '0));

  p_accept_s1_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> s1_vld);

  p_s1_out_r8: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && (!out_valid || out_ready)) |=> out_valid);

  p_bubble_r8: assert property (@(posedge clk) disable iff (rst)
    (!s1_vld && (!out_valid || out_ready)) |=> !out_valid);

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (!out_valid && !s1_vld));
endmodule

bind tile_addr_gen tile_addr_gen_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .s1_vld(s1_vld), .out_valid(out_valid), .out_ready(out_ready),
  .out_addr(out_addr), .out_err(out_err)
);

// File: tb/tile_addr_gen_tb_top.sv
module tile_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_x = '0, in_y = '0, in_pitch = '0, in_org_x = '0, in_org_y = '0;
  logic [1:0]  in_layout = '0;
  logic        in_linear = 1'b0, in_org_en = 1'b0;
  logic [2:0]  in_bpp = 3'd1;
  logic [31:0] in_base = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_addr;
  logic        out_err;

  int n_chk = 0;
  int n_fail = 0;
  int rdy_mode = 0; // 0 random, 1 always, 2 never
  logic [32:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk; // 125 MHz

  tile_addr_gen dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_y(in_y), .in_layout(in_layout), .in_linear(in_linear),
    .in_bpp(in_bpp), .in_pitch(in_pitch), .in_base(in_base),
    .in_org_en(in_org_en), .in_org_x(in_org_x), .in_org_y(in_org_y),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_err(out_err)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // reference: integer division form of the requirements
  function automatic logic [32:0] model(longint x, longint y, int lay, bit lin, longint bpp,
                                        longint pitch, longint base, bit oe, longint ox, longint oy);
    longint xx, yy, off, tpr, mw, bw;
    xx = oe ? (x + ox) % 65536 : x;
    yy = oe ? (y + oy) % 65536 : y;
    if (!(bpp == 1 || bpp == 2 || bpp == 4)) return {1'b1, 32'd0};
    if (lin || lay == 0) off = xx * bpp + yy * pitch;
    else if (lay == 1) begin
      mw = 32 / bpp; tpr = (pitch + 31) / 32;
      off = yy * tpr * 32 + (xx / mw) * 32 + (xx % mw) * bpp;
    end else if (lay == 2) begin
      mw = 32 / bpp; bw = 256 / bpp; tpr = pitch / bw;
      off = (yy / 8) * tpr * 2048 + (yy % 8) * 256 + (xx / bw) * 2048
          + ((xx % bw) / mw) * 32 + (xx % mw) * bpp;
    end else begin
      mw = 16 / bpp; bw = 128 / bpp; tpr = pitch / bw;
      off = (yy / 16) * tpr * 2048 + ((yy % 16) / 2) * 256 + (yy % 2) * 16
          + (xx / bw) * 2048 + ((xx % bw) / mw) * 32 + (xx % mw) * bpp;
    end
    return {1'b0, 32'((base + off) & 64'hFFFF_FFFF)};
  endfunction

  // driver: pushes the expected item once the request is accepted
  task automatic send(input int x, input int y, input int lay, input bit lin, input int bpp,
                      input int pitch, input longint base, input bit oe, input int ox,
                      input int oy, input string tag);
    @(negedge clk);
    in_x = 16'(x); in_y = 16'(y); in_layout = 2'(lay); in_linear = lin;
    in_bpp = 3'(bpp); in_pitch = 16'(pitch); in_base = 32'(base);
    in_org_en = oe; in_org_x = 16'(ox); in_org_y = 16'(oy);
    in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk); #1;
    end
    exp_q.push_back(model(x, y, lay, lin, bpp, pitch, base, oe, ox, oy));
    tag_q.push_back(tag);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // monitor: sets out_ready mid-cycle and scores the transfer at the next edge
  initial begin
    logic [32:0] e;
    string t;
    forever begin
      @(negedge clk);
      case (rdy_mode)
        1: out_ready = 1'b1;
        2: out_ready = 1'b0;
        default: out_ready = ($urandom % 4) != 0;
      endcase
      if (!rst && out_valid && out_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected result", 1, 0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_err == e[32], {t, " err"}, out_err, e[32]);
          check(out_addr == e[31:0], {t, " addr"}, out_addr, e[31:0]);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R8 watchdog: pending=%0d expected 0", exp_q.size());
    report();
    $finish;
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    logic [31:0] held;
    int bpps[3] = '{1, 2, 4};
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R10 reset out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R10 reset in_ready", in_ready, 1);

    // R8 latency with an always-ready sink
    rdy_mode = 1;
    repeat (2) @(negedge clk);
    send(100, 37, 3, 0, 4, 640, 32'h1000, 0, 0, 0, "R8 R4");
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R8 not after one edge", out_valid, 0);
    @(negedge clk); #1;
    check(out_valid == 1'b1, "R8 valid after two edges", out_valid, 1);
    drain();

    // tile-edge corners per pixel size
    for (int b = 0; b < 3; b++) begin
      int bp = bpps[b];
      send(32 / bp - 1, 1, 1, 0, bp, 70, 0, 0, 0, 0, "R2 edge");
      send(32 / bp, 2, 1, 0, bp, 33, 0, 0, 0, 0, "R2 edge");
      send(256 / bp - 1, 7, 2, 0, bp, 2048, 0, 0, 0, 0, "R3 edge");
      send(256 / bp, 8, 2, 0, bp, 1024, 0, 0, 0, 0, "R3 edge");
      send(128 / bp - 1, 15, 3, 0, bp, 1024, 0, 0, 0, 0, "R4 edge");
      send(128 / bp, 16, 3, 0, bp, 512, 0, 0, 0, 0, "R4 edge");
      send(16 / bp, 1, 3, 0, bp, 512, 0, 0, 0, 0, "R4 odd row");
    end
    rdy_mode = 0;

    // randomized sweep over every layout and pixel size
    for (int lay = 0; lay < 4; lay++) begin
      for (int b = 0; b < 3; b++) begin
        repeat (10) begin
          string tg;
          case (lay)
            0: tg = "R1 R7 linear";
            1: tg = "R2 R7 micro";
            2: tg = "R3 R7 macro";
            default: tg = "R4 R7 both";
          endcase
          send($urandom % 65536, $urandom % 65536, lay, 0, bpps[b], $urandom % 65536,
               $urandom, 0, $urandom % 65536, $urandom % 65536, tg);
        end
      end
    end

    // R1 bypass overrides tiling
    repeat (6) send($urandom % 4096, $urandom % 4096, 1 + $urandom % 3, 1, bpps[$urandom % 3],
                    $urandom % 65536, $urandom, 0, 0, 0, "R1 bypass");
    // R5 origin add, with wrap
    repeat (6) send($urandom % 65536, $urandom % 65536, $urandom % 4, 0, bpps[$urandom % 3],
                    $urandom % 65536, $urandom, 1, $urandom % 65536, $urandom % 65536, "R5 origin");
    send(65535, 65535, 3, 0, 2, 4096, 0, 1, 2, 3, "R5 wrap");
    // R7 base wrap
    send(10, 20, 0, 0, 4, 100, 64'hFFFF_FFF0, 0, 0, 0, "R7 base wrap");
    // R6 illegal pixel sizes
    send(5, 5, 3, 0, 0, 256, 32'h55, 0, 0, 0, "R6 bpp0");
    send(5, 5, 0, 0, 3, 256, 32'h55, 0, 0, 0, "R6 bpp3");
    send(5, 5, 2, 0, 5, 256, 32'h55, 0, 0, 0, "R6 bpp5");
    send(5, 5, 1, 1, 7, 256, 32'h55, 0, 0, 0, "R6 bpp7");
    drain();

    // R9 back-pressure hold
    rdy_mode = 2;
    @(negedge clk);
    send(300, 41, 2, 0, 2, 2048, 32'h8000, 0, 0, 0, "R9 held");
    repeat (2) @(negedge clk);
    #1;
    check(out_valid == 1'b1, "R9 valid under stall", out_valid, 1);
    check(in_ready == 1'b0, "R9 in_ready low under stall", in_ready, 0);
    held = out_addr;
    repeat (4) @(negedge clk);
    #1;
    check(out_valid == 1'b1, "R9 still valid", out_valid, 1);
    check(out_addr == held, "R9 addr stable", out_addr, held);
    rdy_mode = 0;
    drain();

    // R10 reset while a result is held
    rdy_mode = 2;
    @(negedge clk);
    send(1, 2, 3, 0, 1, 256, 0, 0, 0, 0, "R10 flushed");
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk); #1;
    check(out_valid == 1'b0, "R10 mid-flight reset", out_valid, 0);
    exp_q.delete(); tag_q.delete();
    rst = 1'b0;
    rdy_mode = 0;
    send(9, 9, 0, 0, 1, 64, 0, 0, 0, 0, "R10 after reset R1");
    drain();

    report();
    $finish;
  end
endmodule